// File: doc/BRIEF.md
# Management Region Decoder and Strobe Selector

This block sits between a processor's bus-cycle generator and its external address strobes. For every bus cycle it decides whether the cycle should be announced on the normal address strobe or on the separate strobe that targets management memory. It can also decide that no strobe is issued. It decodes the cycle address against a programmable region. The region is described by a page-aligned base and a 4-bit size code. The block then applies a fixed precedence between the operating mode, the cycle type and two override controls.

The selection is registered. A cycle presented with `cyc_valid` high in one clock produces exactly one strobe pulse in the next clock. The block also reports when the management strobe pin has to be released, which happens whenever the management feature is switched off.

Top module: `mregion_strobe_sel`

## Requirements
- R1: When the size code is 0 the region is disabled, and every valid cycle produces the normal strobe.
- R2: Size codes 1 to 14 give a block of 4 KB shifted left by (code - 1). That covers 4 KB up to 32 MB. An address hits when its bits above the block size equal the same bits of `{cfg_base, 12'h000}`. Base bits below the block size have no effect.
- R3: Size code 15 decodes exactly like size code 1, a 4 KB block.
- R4: In management mode (`in_mgmt`=1) with `cfg_main_acc`=0, every hit produces the management strobe.
- R5: With `cfg_main_acc`=1, a data hit (`cyc_is_code`=0) produces the normal strobe and a code-fetch hit produces the management strobe. This holds in either mode, and it overrides `cfg_normal_acc` when both are set.
- R6: In normal mode (`in_mgmt`=0) with `cfg_normal_acc`=1 and `cfg_main_acc`=0, every hit, whether code or data, produces the management strobe.
- R7: In normal mode with both override bits clear, every valid cycle produces the normal strobe.
- R8: While `cfg_enable`=0 the management strobe is never asserted, and `mgmt_float` reads 1 from the next clock on. It reads 0 one clock after `cfg_enable` is 1.
- R9: A cache write-back cycle (`cyc_is_wb`=1) always produces the normal strobe, even inside the region.
- R10: Addresses outside the region always produce the normal strobe.
- R11: A valid cycle sampled at one clock edge gives exactly one of `strb_norm` or `strb_mgmt` high after that edge. Both are low after an edge where `cyc_valid` was 0.
- R12: During and right after reset, both strobes are 0 and `mgmt_float` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_addr | input | 32 | Byte address of the cycle |
| cyc_is_code | input | 1 | 1 = code fetch, 0 = data read/write |
| cyc_is_wb | input | 1 | 1 = write-back of a dirty cache line |
| in_mgmt | input | 1 | 1 = processor is in management mode |
| cfg_enable | input | 1 | Management feature enable |
| cfg_normal_acc | input | 1 | Let normal mode reach management memory |
| cfg_main_acc | input | 1 | Send management-mode data hits to main memory |
| cfg_base | input | 20 | Region base, address bits 31..12 |
| cfg_size | input | 4 | Region size code |
| strb_norm | output | 1 | Normal address strobe pulse |
| strb_mgmt | output | 1 | Management address strobe pulse |
| mgmt_float | output | 1 | Management strobe pin must be released |

## Verification
Two cases are the hardest to reach from the ports. The first is the edges of each region size when the base carries stray low bits. Getting there requires stepping the size code through all fourteen real values and probing four addresses around the aligned block for each: its first byte, its last byte, one past the end and one below the start. The second is the precedence corner, where both override bits are set in normal mode. It is reached with back-to-back code and data cycles at the same hit address, and the bench then compares those against a write-back cycle at that address. The bench model computes region membership from byte arithmetic on the aligned base and the size, not from bit masks.

// File: rtl/mregion_pkg.sv
// Package: shared types for the management region strobe selector.
// Assumes: consumers import it before use.
package mregion_pkg;
    // Which strobe a cycle should raise
    typedef enum logic [1:0] {
        STB_NONE = 2'd0,
        STB_NORM = 2'd1,
        STB_MGMT = 2'd2
    } stb_sel_e;
endpackage

// File: rtl/mregion_match.sv
// Module: mregion_match
// Decides whether an address falls inside the management region.
// Assumes: size code 0 disables, the all-ones code aliases to code 1,
// and code c covers 2^(PAGE_SHIFT + c - 1) bytes. Base bits under the
// block size are masked off.
module mregion_match #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SIZE_W     = 4
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] base,
    input  logic [SIZE_W-1:0]            size_code,
    input  logic                         enable,
    output logic                         hit
);
    localparam int BASE_W = ADDR_W - PAGE_SHIFT;
    localparam logic [SIZE_W-1:0] ALIAS_CODE = {SIZE_W{1'b1}};

    logic [SIZE_W-1:0] eff_code;
    logic [SIZE_W-1:0] shift;
    logic [BASE_W-1:0] keep_mask;
    logic [BASE_W-1:0] diff;

    // Fold the alias code onto the smallest block and derive the page shift
    always_comb begin
        eff_code = (size_code == ALIAS_CODE) ? SIZE_W'(1) : size_code;
        shift    = eff_code - SIZE_W'(1);
    end

    // Build the compare mask: page bits at or above the shift are compared
    for (genvar gi = 0; gi < BASE_W; gi++) begin : g_mask
        assign keep_mask[gi] = (32'(gi) >= 32'(shift));
    end

    // Final region decision
    always_comb begin
        diff = (addr[ADDR_W-1:PAGE_SHIFT] ^ base) & keep_mask;
        hit  = enable && (size_code != '0) && (diff == '0);
    end
endmodule

// File: rtl/mregion_policy.sv
// Module: mregion_policy
// Applies the precedence between cycle type, mode and override bits.
// Assumes: a cycle that misses is decided before any mode rule, and
// write-back cycles bypass the region entirely.
module mregion_policy
    import mregion_pkg::*;
(
    input  logic     hit,
    input  logic     is_code,
    input  logic     is_wb,
    input  logic     in_mgmt,
    input  logic     normal_acc,
    input  logic     main_acc,
    output stb_sel_e sel
);
    // Strobe selection with fixed precedence: write-back, miss, main-access, mode
    always_comb begin
        if (is_wb || !hit)        sel = STB_NORM;
        else if (main_acc)        sel = is_code ? STB_MGMT : STB_NORM;
        else if (in_mgmt)         sel = STB_MGMT;
        else if (normal_acc)      sel = STB_MGMT;
        else                      sel = STB_NORM;
    end
endmodule

// File: rtl/mregion_strobe_sel.sv
// Module: mregion_strobe_sel (top)
// Registers the strobe choice for each valid bus cycle and the float flag.
// Assumes: one cycle per clock at most; outputs are one-clock pulses
// issued the clock after the cycle is presented.
module mregion_strobe_sel
    import mregion_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SIZE_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cyc_valid,
    input  logic [ADDR_W-1:0]            cyc_addr,
    input  logic                         cyc_is_code,
    input  logic                         cyc_is_wb,
    input  logic                         in_mgmt,
    input  logic                         cfg_enable,
    input  logic                         cfg_normal_acc,
    input  logic                         cfg_main_acc,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_base,
    input  logic [SIZE_W-1:0]            cfg_size,
    output logic                         strb_norm,
    output logic                         strb_mgmt,
    output logic                         mgmt_float
);
    logic     region_hit;
    stb_sel_e pick;
    stb_sel_e pick_q;

    mregion_match #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .SIZE_W    (SIZE_W)
    ) u_match (
        .addr     (cyc_addr),
        .base     (cfg_base),
        .size_code(cfg_size),
        .enable   (cfg_enable),
        .hit      (region_hit)
    );

    mregion_policy u_policy (
        .hit       (region_hit),
        .is_code   (cyc_is_code),
        .is_wb     (cyc_is_wb),
        .in_mgmt   (in_mgmt),
        .normal_acc(cfg_normal_acc),
        .main_acc  (cfg_main_acc),
        .sel       (pick)
    );

    // Capture the chosen strobe for a valid cycle and track the float state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q     <= STB_NONE;
            mgmt_float <= 1'b1;
        end else begin
            pick_q     <= cyc_valid ? pick : STB_NONE;
            mgmt_float <= !cfg_enable;
        end
    end

    // Decode the registered choice onto the two strobe pins
    always_comb begin
        strb_norm = (pick_q == STB_NORM);
        strb_mgmt = (pick_q == STB_MGMT);
    end
endmodule

// File: rtl/mregion_strobe_sel_chk.sv
// Module: mregion_strobe_sel_chk
// Temporal checks on the strobe selector, bound to every instance.
// Assumes: inputs are driven to known values from time zero.
module mregion_strobe_sel_chk #(
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_valid,
    input logic              cyc_is_code,
    input logic              cyc_is_wb,
    input logic              in_mgmt,
    input logic              cfg_enable,
    input logic              cfg_normal_acc,
    input logic              cfg_main_acc,
    input logic [SIZE_W-1:0] cfg_size,
    input logic              strb_norm,
    input logic              strb_mgmt,
    input logic              mgmt_float
);
    // R11: a strobe follows a valid cycle, and no strobe follows an idle one
    a_r11_one_strobe_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((strb_norm || strb_mgmt) == $past(cyc_valid)));

    // R11: never both strobes
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strb_norm, strb_mgmt}));

    // R8: the management strobe stays silent while the feature is off
    a_r8_no_mgmt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_enable)) |-> !strb_mgmt);

    // R8: while released, the float flag is high
    a_r8_float_blocks_mgmt: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_float |-> !strb_mgmt);

    // R9: write-back cycles go to main memory
    a_r9_wb_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cyc_valid && cyc_is_wb)) |-> strb_norm);

    // R1: a zero size code never yields a management strobe
    a_r1_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cyc_valid && cfg_size == '0)) |-> strb_norm);

    // R5: data cycles with main access set use the normal strobe
    a_r5_data_main: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cyc_valid && cfg_main_acc && !cyc_is_code)) |-> strb_norm);

    // R7: normal mode without overrides uses the normal strobe
    a_r7_plain_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cyc_valid && !in_mgmt && !cfg_normal_acc && !cfg_main_acc))
        |-> strb_norm);
endmodule

bind mregion_strobe_sel mregion_strobe_sel_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_valid     (cyc_valid),
    .cyc_is_code   (cyc_is_code),
    .cyc_is_wb     (cyc_is_wb),
    .in_mgmt       (in_mgmt),
    .cfg_enable    (cfg_enable),
    .cfg_normal_acc(cfg_normal_acc),
    .cfg_main_acc  (cfg_main_acc),
    .cfg_size      (cfg_size),
    .strb_norm     (strb_norm),
    .strb_mgmt     (strb_mgmt),
    .mgmt_float    (mgmt_float)
);

// File: tb/mregion_strobe_sel_bench.sv
// Directed bench for the management region strobe selector.
module mregion_strobe_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_is_code = 1'b0;
    logic        cyc_is_wb = 1'b0;
    logic        in_mgmt = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_normal_acc = 1'b0;
    logic        cfg_main_acc = 1'b0;
    logic [19:0] cfg_base = '0;
    logic [3:0]  cfg_size = '0;
    logic        strb_norm, strb_mgmt, mgmt_float;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mregion_strobe_sel u_mregion_strobe_sel (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_is_code(cyc_is_code), .cyc_is_wb(cyc_is_wb), .in_mgmt(in_mgmt),
        .cfg_enable(cfg_enable), .cfg_normal_acc(cfg_normal_acc),
        .cfg_main_acc(cfg_main_acc), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .strb_norm(strb_norm), .strb_mgmt(strb_mgmt), .mgmt_float(mgmt_float)
    );

    // Compare one 2-bit or 1-bit observation against its expectation
    task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Region membership from byte arithmetic on the aligned base
    function automatic bit model_hit(logic [31:0] a);
        longint unsigned sz, lo;
        int c;
        if (!cfg_enable || cfg_size == 4'd0) return 1'b0;
        c  = (cfg_size == 4'hF) ? 1 : int'(cfg_size);
        sz = longint'(4096) << (c - 1);
        lo = longint'({cfg_base, 12'h000}) & ~(sz - 1);
        return (longint'(a) >= lo) && (longint'(a) < lo + sz);
    endfunction

    // Expected {mgmt, norm} for a cycle under the current settings
    function automatic logic [2:0] model_sel(logic [31:0] a, bit code, bit wb);
        bit m;
        if (wb || !model_hit(a))     m = 1'b0;
        else if (cfg_main_acc)       m = code;
        else if (in_mgmt)            m = 1'b1;
        else if (cfg_normal_acc)     m = 1'b1;
        else                         m = 1'b0;
        return {1'b0, m, !m};
    endfunction

    // Present one cycle, then sample the strobes one clock later
    task automatic run(string tag, logic [31:0] a, bit code, bit wb);
        logic [2:0] exp;
        exp = model_sel(a, code, wb);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_addr = a; cyc_is_code = code; cyc_is_wb = wb;
        @(negedge clk);
        cyc_valid = 1'b0;
        check(tag, {1'b0, strb_mgmt, strb_norm}, exp);
    endtask

    task automatic set_cfg(bit en, bit na, bit ma, bit mode, logic [19:0] b, logic [3:0] s);
        @(negedge clk);
        cfg_enable = en; cfg_normal_acc = na; cfg_main_acc = ma;
        in_mgmt = mode; cfg_base = b; cfg_size = s;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 reset strobes/float", {strb_mgmt, strb_norm, mgmt_float}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", {strb_mgmt, strb_norm, mgmt_float}, 3'b001);
    endtask

    task automatic t_sizes();
        longint unsigned sz, lo;
        for (int c = 1; c <= 14; c++) begin
            set_cfg(1, 0, 0, 1, 20'h12345, 4'(c));
            sz = longint'(4096) << (c - 1);
            lo = longint'({20'h12345, 12'h000}) & ~(sz - 1);
            run($sformatf("R2 code%0d first", c), 32'(lo), 0, 0);
            run($sformatf("R2 code%0d last", c), 32'(lo + sz - 1), 0, 0);
            run($sformatf("R10 code%0d past end", c), 32'(lo + sz), 0, 0);
            run($sformatf("R10 code%0d below", c), 32'(lo - 1), 0, 0);
        end
    endtask

    task automatic t_alias();
        set_cfg(1, 0, 0, 1, 20'h00068, 4'hF);
        run("R3 alias inside", 32'h0006_8FFC, 0, 0);
        run("R3 alias past 4K", 32'h0006_9000, 0, 0);
        check("R3 alias hit", {1'b0, model_hit(32'h0006_8000), model_hit(32'h0006_9000)}, 3'b010);
    endtask

    task automatic t_size_zero();
        set_cfg(1, 1, 0, 1, 20'h00068, 4'h0);
        run("R1 size zero mgmt", 32'h0006_8000, 1, 0);
        set_cfg(1, 1, 0, 0, 20'h00068, 4'h0);
        run("R1 size zero normal", 32'h0006_8000, 0, 0);
    endtask

    task automatic t_mgmt_mode();
        set_cfg(1, 0, 0, 1, 20'h00068, 4'h3);
        run("R4 mgmt data", 32'h0006_8100, 0, 0);
        run("R4 mgmt code", 32'h0006_B000, 1, 0);
        run("R10 mgmt outside", 32'h0006_C000, 1, 0);
        set_cfg(1, 0, 1, 1, 20'h00068, 4'h3);
        run("R5 mgmt main data", 32'h0006_8100, 0, 0);
        run("R5 mgmt main code", 32'h0006_8100, 1, 0);
    endtask

    task automatic t_normal_mode();
        set_cfg(1, 1, 0, 0, 20'h00068, 4'h3);
        run("R6 normal acc data", 32'h0006_8100, 0, 0);
        run("R6 normal acc code", 32'h0006_8100, 1, 0);
        set_cfg(1, 0, 0, 0, 20'h00068, 4'h3);
        run("R7 plain data", 32'h0006_8100, 0, 0);
        run("R7 plain code", 32'h0006_8100, 1, 0);
        set_cfg(1, 1, 1, 0, 20'h00068, 4'h3);
        run("R5 both set data", 32'h0006_8100, 0, 0);
        run("R5 both set code", 32'h0006_8100, 1, 0);
    endtask

    task automatic t_enable_off();
        set_cfg(0, 1, 0, 1, 20'h00068, 4'h3);
        @(negedge clk);
        check("R8 float high", {2'b00, mgmt_float}, 3'b001);
        run("R8 off mgmt code", 32'h0006_8100, 1, 0);
        run("R8 off normal acc", 32'h0006_8100, 0, 0);
        set_cfg(1, 1, 0, 1, 20'h00068, 4'h3);
        @(negedge clk);
        check("R8 float low", {2'b00, mgmt_float}, 3'b000);
    endtask

    task automatic t_writeback();
        set_cfg(1, 0, 0, 1, 20'h00068, 4'h3);
        run("R9 wb mgmt mode", 32'h0006_8100, 0, 1);
        set_cfg(1, 1, 1, 0, 20'h00068, 4'h3);
        run("R9 wb both set", 32'h0006_8100, 1, 1);
    endtask

    task automatic t_idle();
        set_cfg(1, 0, 0, 1, 20'h00068, 4'h3);
        cyc_addr = 32'h0006_8100;
        @(negedge clk);
        @(negedge clk);
        check("R11 idle no strobe", {1'b0, strb_mgmt, strb_norm}, 3'b000);
        run("R11 single strobe", 32'h0006_8100, 0, 0);
        @(negedge clk);
        check("R11 pulse ends", {1'b0, strb_mgmt, strb_norm}, 3'b000);
    endtask

    initial begin
        t_reset();
        t_sizes();
        t_alias();
        t_size_zero();
        t_mgmt_mode();
        t_normal_mode();
        t_enable_off();
        t_writeback();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule